// File: doc/BRIEF.md
# Word-Serial Modular Adder/Subtractor

This block adds or subtracts two field elements modulo a programmable odd modulus p. Both operands and the result are 136-bit values kept in the relaxed range [0, 2p). They travel over 34-bit buses, least significant word first. The relaxed range is the one used by Montgomery-domain multipliers, so results can go straight back into a multiplier without a final reduction to [0, p).

An operation starts with a one-cycle start strobe. On that strobe the block samples the add/subtract mode and the first operand words. It takes the remaining three word pairs on the three cycles that follow. Two carry chains run side by side, one word per cycle. The first chain forms the raw result: x + y, or x plus the two's complement of y. The second chain forms the raw result corrected by 2p: minus 2p for an add, plus 2p for a subtract. Both are stored word by word. Once the final carries are known, one of the two is picked and streamed out on four consecutive cycles, followed by a one-cycle done pulse. The cycle count is the same for every operand value and mode. The modulus is written through a separate load strobe while the block is idle.

Top module: `wsmod_addsub`

## Requirements
- R1: While reset is held, and after it is released until the first start, res_valid and done are 0 and res_word is 0.
- R2: In add mode (sub_mode = 0 at start) the result is x + y when x + y < 2p. Otherwise it is x + y − 2p. This includes sums that reach or exceed 2^136, for example x = y = 2p − 1 gives 2p − 2, and x = y = p gives 0.
- R3: In subtract mode (sub_mode = 1 at start) the result is x − y when x ≥ y. Otherwise it is x − y + 2p. For example x = y gives 0, and x = 0, y = 2p − 1 gives 1.
- R4: The mode is taken only from the start cycle. Changing sub_mode on later cycles of the operation does not change the result.
- R5: Operand word i (i = 0..3, word 0 = bits 33:0) is taken on the start cycle plus i. Result words come out with res_valid high on four consecutive cycles, least significant word first. The first of them is the cycle after the last operand word is taken.
- R6: done is high for exactly one cycle, the cycle right after the last result word.
- R7: A start that arrives while an operation is in progress (from the cycle after an accepted start through the done cycle) is ignored. It neither disturbs the running result nor produces extra result words.
- R8: mod_load, when sampled high while the block is idle, stores mod_p as the new p. When sampled high during an operation it is ignored, and p keeps its old value.
- R9: Counting the rising edge that samples start as edge 1, done is high after edge 8 for every operand value and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_load | input | 1 | Store mod_p as the modulus (idle only) |
| mod_p | input | 135 | Modulus p, must satisfy p < 2^135 |
| start | input | 1 | Begin an operation (idle only) |
| sub_mode | input | 1 | 0 = add, 1 = subtract; sampled with start |
| opx_word | input | 34 | Current word of operand x |
| opy_word | input | 34 | Current word of operand y |
| res_valid | output | 1 | res_word carries a result word |
| res_word | output | 34 | Current result word, 0 when not valid |
| done | output | 1 | One-cycle pulse after the last result word |

## Verification
The embedded assertions check the sequencing on every cycle. They check that done lasts a single cycle and always follows a result word, that an accepted start always leaves the idle state, that the result stream begins only right after the final operand word, and that the stored modulus and the chosen candidate stay fixed while an operation runs. The numerical correctness of the two candidate chains and of the carry-based choice is visible only in the bench's scenarios. The same holds for the fixed latency and for the effect of ignored start, mode and load strobes. The bench compares whole reassembled results against an independent wide-integer model, including sums past 2^136 and differences that wrap below zero.

// File: rtl/wsmod_pkg.sv
package wsmod_pkg;

  localparam int unsigned WORD_W_DEF = 34;
  localparam int unsigned NUM_WORDS_DEF = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_EMIT = 2'd2,
    SEQ_DONE = 2'd3
  } seq_state_e;

  // Pick the 2p-corrected candidate from the final carries of both chains.
  // Add: raw >= 2p when the raw chain overflowed or raw + (2^n - 2p) carried.
  // Sub: raw is negative when x + ~y + 1 produced no carry.
  function automatic logic take_corrected(input logic is_sub,
                                          input logic raw_co,
                                          input logic cor_co);
    return is_sub ? ~raw_co : (raw_co | cor_co);
  endfunction

endpackage

// File: rtl/wsmod_word_add.sv
module wsmod_word_add #(
  parameter int unsigned W = 34
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
  end
endmodule

// File: rtl/wsmod_seq.sv
module wsmod_seq
  import wsmod_pkg::*;
#(
  parameter int unsigned NW = 4,
  localparam int unsigned CW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          idle,
  output logic          accept,
  output logic          take_in,
  output logic          last_in,
  output logic          emit,
  output logic          done,
  output logic [CW-1:0] idx
);
  localparam logic [CW-1:0] LAST = CW'(NW - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    idle    = (state_q == SEQ_IDLE);
    accept  = idle && start;
    take_in = accept || (state_q == SEQ_LOAD);
    last_in = (state_q == SEQ_LOAD) && (cnt_q == LAST);
    emit    = (state_q == SEQ_EMIT);
    done    = (state_q == SEQ_DONE);
    idx     = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_LOAD;
          cnt_q   <= CW'(1);
        end
        SEQ_LOAD: if (cnt_q == LAST) begin
          state_q <= SEQ_EMIT;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        SEQ_EMIT: if (cnt_q == LAST) begin
          state_q <= SEQ_DONE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        default: begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(emit));

  // R7
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !idle);

endmodule

// File: rtl/wsmod_addsub.sv
module wsmod_addsub
  import wsmod_pkg::*;
#(
  parameter int unsigned WORD_W    = WORD_W_DEF,
  parameter int unsigned NUM_WORDS = NUM_WORDS_DEF,
  localparam int unsigned FULL_W   = WORD_W * NUM_WORDS,
  localparam int unsigned CW       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_load,
  input  logic [FULL_W-2:0] mod_p,
  input  logic              start,
  input  logic              sub_mode,
  input  logic [WORD_W-1:0] opx_word,
  input  logic [WORD_W-1:0] opy_word,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              done
);
  logic          seq_idle, seq_accept, seq_take, seq_last, seq_emit;
  logic [CW-1:0] seq_idx;

  wsmod_seq #(.NW(NUM_WORDS)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .idle    (seq_idle),
    .accept  (seq_accept),
    .take_in (seq_take),
    .last_in (seq_last),
    .emit    (seq_emit),
    .done    (done),
    .idx     (seq_idx)
  );

  // Modulus stored pre-doubled; only writable while idle.
  logic [FULL_W-1:0] twop_q;
  logic              mode_q;
  logic              raw_c_q, cor_c_q;
  logic              pick_cor_q;
  logic [WORD_W-1:0] raw_buf [NUM_WORDS];
  logic [WORD_W-1:0] cor_buf [NUM_WORDS];

  logic              eff_sub;
  logic [WORD_W-1:0] twop_word, y_eff, k_word;
  logic              raw_cin, cor_cin;
  logic [WORD_W-1:0] raw_word, cor_word;
  logic              raw_co, cor_co;

  always_comb begin
    eff_sub   = seq_idle ? sub_mode : mode_q;
    twop_word = twop_q[seq_idx*WORD_W +: WORD_W];
    y_eff     = eff_sub ? ~opy_word : opy_word;
    k_word    = eff_sub ? twop_word : ~twop_word;
    raw_cin   = seq_idle ? sub_mode : raw_c_q;
    cor_cin   = seq_idle ? ~sub_mode : cor_c_q;
  end

  wsmod_word_add #(.W(WORD_W)) i_raw_add (
    .a    (opx_word),
    .b    (y_eff),
    .cin  (raw_cin),
    .sum  (raw_word),
    .cout (raw_co)
  );

  wsmod_word_add #(.W(WORD_W)) i_cor_add (
    .a    (raw_word),
    .b    (k_word),
    .cin  (cor_cin),
    .sum  (cor_word),
    .cout (cor_co)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twop_q     <= '0;
      mode_q     <= 1'b0;
      raw_c_q    <= 1'b0;
      cor_c_q    <= 1'b0;
      pick_cor_q <= 1'b0;
    end else begin
      if (mod_load && seq_idle) twop_q <= {mod_p, 1'b0};
      if (seq_accept) mode_q <= sub_mode;
      if (seq_take) begin
        raw_c_q <= raw_co;
        cor_c_q <= cor_co;
      end
      if (seq_last) pick_cor_q <= take_corrected(mode_q, raw_co, cor_co);
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_buf[g] <= '0;
        cor_buf[g] <= '0;
      end else if (seq_take && (seq_idx == CW'(g))) begin
        raw_buf[g] <= raw_word;
        cor_buf[g] <= cor_word;
      end
    end
  end

  always_comb begin
    res_valid = seq_emit;
    res_word  = '0;
    if (seq_emit) res_word = pick_cor_q ? cor_buf[seq_idx] : raw_buf[seq_idx];
  end

  // R8
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle |=> $stable(twop_q));

  // R5
  stream_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(seq_last));

  // R5
  pick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_emit && $past(seq_emit)) |-> $stable(pick_cor_q));

  // R6
  stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_valid) |-> done);

endmodule

// File: tb/test_wsmod_addsub.sv
module test_wsmod_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 34;
  localparam int NW = 4;
  localparam int FW = W * NW;
  localparam int NV = 10;

  localparam logic [FW-2:0] PS = 135'd1000003;
  localparam logic [FW-2:0] PB = {135{1'b1}};
  localparam logic [FW-2:0] PM = 135'h0123_4567_89AB_CDEF_0011_2233_4455_6677;
  localparam logic [FW-1:0] TS = {PS, 1'b0};
  localparam logic [FW-1:0] TB = {PB, 1'b0};
  localparam logic [FW-1:0] TM = {PM, 1'b0};

  localparam logic [FW-2:0] VP [NV] = '{PS, PS, PS, PS, PS, PB, PB, PB, PM, PM};
  localparam logic [FW-1:0] VX [NV] = '{136'd5, TS - 136'd1, {1'b0, PS}, 136'd3, 136'd10,
                                        TB - 136'd1, 136'd0, TB - 136'd1,
                                        {1'b0, PM} + 136'd12345, 136'd77};
  localparam logic [FW-1:0] VY [NV] = '{136'd7, TS - 136'd1, {1'b0, PS}, 136'd10, 136'd10,
                                        TB - 136'd1, TB - 136'd1, 136'd0,
                                        {1'b0, PM} - 136'd999, TM - 136'd5};
  localparam logic VS [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mod_load = 1'b0;
  logic [FW-2:0] mod_p = '0;
  logic          start = 1'b0;
  logic          sub_mode = 1'b0;
  logic [W-1:0]  opx_word = '0;
  logic [W-1:0]  opy_word = '0;
  logic          res_valid;
  logic [W-1:0]  res_word;
  logic          done;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wsmod_addsub i_wsmod_addsub (
    .clk(clk), .rst_n(rst_n), .mod_load(mod_load), .mod_p(mod_p),
    .start(start), .sub_mode(sub_mode), .opx_word(opx_word), .opy_word(opy_word),
    .res_valid(res_valid), .res_word(res_word), .done(done)
  );

  function automatic logic [FW-1:0] model(input logic [FW-2:0] p, input logic [FW-1:0] x,
                                          input logic [FW-1:0] y, input logic sub);
    logic [FW:0] tp, xe, ye, s;
    tp = {1'b0, p, 1'b0};
    xe = {1'b0, x};
    ye = {1'b0, y};
    if (!sub) begin
      s = xe + ye;
      if (s >= tp) s = s - tp;
    end else if (xe >= ye) begin
      s = xe - ye;
    end else begin
      s = xe + tp - ye;
    end
    return s[FW-1:0];
  endfunction

  task automatic check(input string req, input logic [FW-1:0] got, input logic [FW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_mod(input logic [FW-2:0] p);
    @(negedge clk);
    mod_load = 1'b1;
    mod_p = p;
    @(negedge clk);
    mod_load = 1'b0;
  endtask

  task automatic run_op(input logic [FW-1:0] x, input logic [FW-1:0] y, input logic sub,
                        input logic noisy, output logic [FW-1:0] res, output int lat,
                        output int nw, output logic done_twice);
    res = '0; lat = 0; nw = 0; done_twice = 1'b0;
    @(negedge clk);
    start = 1'b1; sub_mode = sub; opx_word = x[W-1:0]; opy_word = y[W-1:0];
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      sub_mode = ~sub;
      start = noisy && (k < 2 * NW);
      if (k < NW) begin
        opx_word = x[k*W +: W];
        opy_word = y[k*W +: W];
      end else begin
        opx_word = ~opx_word;
        opy_word = ~opy_word;
      end
      if (res_valid) begin
        if (nw < NW) res[nw*W +: W] = res_word;
        nw++;
      end
      if (done) begin
        lat = k;
        start = 1'b0;
        @(negedge clk);
        done_twice = done;
        break;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [FW-1:0] res;
    int lat, nw;
    logic d2;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {135'd0, res_valid}, '0);
    check("R1 done in reset", {135'd0, done}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {101'd0, res_valid, done, res_word}, '0);

    // Vector table: R2 (add) / R3 (sub), with mode flipped after start (R4)
    for (int i = 0; i < NV; i++) begin
      load_mod(VP[i]);
      run_op(VX[i], VY[i], VS[i], 1'b0, res, lat, nw, d2);
      check(VS[i] ? "R3 R4 sub result" : "R2 R4 add result", res,
            model(VP[i], VX[i], VY[i], VS[i]));
      check("R9 latency", FW'(lat), FW'(2 * NW));
      check("R5 word count", FW'(nw), FW'(NW));
      check("R6 done one cycle", {135'd0, d2}, '0);
    end

    // R7: start pulses while busy are ignored
    load_mod(PM);
    run_op(TM - 136'd1, 136'd9, 1'b1, 1'b1, res, lat, nw, d2);
    check("R7 result with busy starts", res, model(PM, TM - 136'd1, 136'd9, 1'b1));
    check("R7 no extra words", FW'(nw), FW'(NW));
    check("R7 latency", FW'(lat), FW'(2 * NW));
    repeat (3) begin
      @(negedge clk);
      check("R7 no stray output", {135'd0, res_valid | done}, '0);
    end

    // R8: load during an operation is ignored
    load_mod(PS);
    fork
      run_op(TS - 136'd1, 136'd1, 1'b0, 1'b0, res, lat, nw, d2);
      begin
        repeat (3) @(negedge clk);
        mod_load = 1'b1;
        mod_p = PB;
        @(negedge clk);
        mod_load = 1'b0;
      end
    join
    check("R8 busy load ignored (same op)", res, '0);
    run_op(TS - 136'd1, 136'd1, 1'b0, 1'b0, res, lat, nw, d2);
    check("R8 busy load ignored (next op)", res, '0);
    load_mod(PB);
    run_op(TS - 136'd1, 136'd1, 1'b0, 1'b0, res, lat, nw, d2);
    check("R8 idle load applied", res, TS);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule